// File: doc/BRIEF.md
# Transceiver-State GPIO Bank

This block is a bank of general-purpose pins controlled through a small register bus. Each pin has two value sources. In manual mode the pin takes its value from an output register. In automatic mode it takes its value from one of four state registers. The radio's live transmit and receive activity flags pick which state register is used, so a pin can follow the transceiver state without software involvement.

The block drives a per-pin output value and a per-pin output enable into external tristate pads. It samples the pad levels back through a two-flop synchronizer, so software can read both the input pins and its own driven pins. Every register write carries a value and a bit mask, and only the bits selected by the mask change.

Top module: `atr_pin_bank`

## Requirements
- R1: After reset every register (mode select, direction, manual value and the four state registers) holds zero. `pinOe` is therefore all zero and `pinOut` is all zero.
- R2: A write with `wrEn` high changes only the bits set in `wrMask`. Those bits take the value in `wrData`, and all other bits keep their previous value.
- R3: `pinOe` equals the direction register (address 1), with 1 meaning driven. This holds in both manual and automatic mode, and a write to the mode-select register does not change it.
- R4: A pin whose mode-select bit (address 0) is 0 drives the bit from the manual value register (address 2).
- R5: A pin whose mode-select bit is 1 drives the bit from the state register picked by {txActive, rxActive}: 00 picks the idle register (address 3), 01 the receive-only register (address 4), 10 the transmit-only register (address 5), and 11 the full-duplex register (address 6).
- R6: `pinOut` is registered. It changes on the first rising clock edge after the activity flags or a register change, not before.
- R7: Reading address 7 returns the pin levels after a two-flop synchronizer. A change on `pinIn` shows up on the read after the second rising edge, and not after the first.
- R8: Writes to address 7 are ignored. A read of addresses 0 to 6 returns the current register contents on the same cycle. Bits at and above PIN_COUNT read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write word address |
| wrData | input | 32 | Write value |
| wrMask | input | 32 | Per-bit write mask, 1 = bit updated |
| rdAddr | input | 3 | Read word address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| txActive | input | 1 | Transmitter busy flag |
| rxActive | input | 1 | Receiver busy flag |
| pinIn | input | PIN_COUNT | Sampled pad levels |
| pinOut | output | PIN_COUNT | Pad output values |
| pinOe | output | PIN_COUNT | Pad output enables |

## Verification
The bench walks all four activity states with a mix of manual and automatic pins. A design that decoded the state bits in the wrong order would show the transmit pattern while only receiving. It checks that a masked write leaves the unmasked bits alone, since a design that ignored the mask would wipe the direction bits. It checks the pin output one edge early, which catches a combinational output path. It checks the readback after one edge and after two, which catches a synchronizer that is missing a stage. It writes to the readback address and confirms that no register changed and that bits above the pin width read zero.

// File: rtl/atr_pin_pkg.sv
package atr_pin_pkg;
  localparam int BUS_W       = 32;
  localparam int ADDR_W      = 3;
  localparam int NUM_WR_REGS = 7;

  typedef enum logic [ADDR_W-1:0] {
    RegMode   = 3'd0,
    RegDir    = 3'd1,
    RegManual = 3'd2,
    RegIdle   = 3'd3,
    RegRxOnly = 3'd4,
    RegTxOnly = 3'd5,
    RegDuplex = 3'd6,
    RegPins   = 3'd7
  } regAddrE;

  typedef struct packed {
    logic [NUM_WR_REGS-1:0] wrSel;
    logic [BUS_W-1:0]       wrData;
    logic [BUS_W-1:0]       wrMask;
    regAddrE                rdSel;
  } busStrobeT;
endpackage

// File: rtl/atr_pin_ctrl.sv
module atr_pin_ctrl
  import atr_pin_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [BUS_W-1:0]  wrMask,
  input  logic [ADDR_W-1:0] rdAddr,
  output busStrobeT         strobe
);
  logic [NUM_WR_REGS-1:0] selVec;

  // One write strobe per writable register; address 7 has none.
  for (genvar i = 0; i < NUM_WR_REGS; i++) begin : g_sel
    assign selVec[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  always_comb begin
    strobe.wrSel  = selVec;
    strobe.wrData = wrData;
    strobe.wrMask = wrMask;
    strobe.rdSel  = regAddrE'(rdAddr);
  end
endmodule

// File: rtl/atr_pin_datapath.sv
module atr_pin_datapath
  import atr_pin_pkg::*;
#(
  parameter int PIN_COUNT = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobeT            strobe,
  input  logic                 txActive,
  input  logic                 rxActive,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [BUS_W-1:0]     rdData
);
  logic [PIN_COUNT-1:0] regFile [NUM_WR_REGS];
  logic [PIN_COUNT-1:0] pinSync1, pinSync2;
  logic [PIN_COUNT-1:0] stateVal, nextOut;
  logic [PIN_COUNT-1:0] maskBits, dataBits;

  assign maskBits = strobe.wrMask[PIN_COUNT-1:0];
  assign dataBits = strobe.wrData[PIN_COUNT-1:0];

  for (genvar i = 0; i < NUM_WR_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[i] <= '0;
      else if (strobe.wrSel[i])
        regFile[i] <= (regFile[i] & ~maskBits) | (dataBits & maskBits);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinSync1 <= '0;
      pinSync2 <= '0;
    end else begin
      pinSync1 <= pinIn;
      pinSync2 <= pinSync1;
    end
  end

  always_comb begin
    unique case ({txActive, rxActive})
      2'b00:   stateVal = regFile[RegIdle];
      2'b01:   stateVal = regFile[RegRxOnly];
      2'b10:   stateVal = regFile[RegTxOnly];
      default: stateVal = regFile[RegDuplex];
    endcase
    nextOut = (regFile[RegMode] & stateVal) | (~regFile[RegMode] & regFile[RegManual]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinOut <= '0;
    else       pinOut <= nextOut;
  end

  assign pinOe = regFile[RegDir];

  always_comb begin
    unique case (strobe.rdSel)
      RegMode:   rdData = BUS_W'(regFile[RegMode]);
      RegDir:    rdData = BUS_W'(regFile[RegDir]);
      RegManual: rdData = BUS_W'(regFile[RegManual]);
      RegIdle:   rdData = BUS_W'(regFile[RegIdle]);
      RegRxOnly: rdData = BUS_W'(regFile[RegRxOnly]);
      RegTxOnly: rdData = BUS_W'(regFile[RegTxOnly]);
      RegDuplex: rdData = BUS_W'(regFile[RegDuplex]);
      default:   rdData = BUS_W'(pinSync2);
    endcase
  end
endmodule

// File: rtl/atr_pin_bank.sv
module atr_pin_bank
  import atr_pin_pkg::*;
#(
  parameter int PIN_COUNT = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           wrAddr,
  input  logic [31:0]          wrData,
  input  logic [31:0]          wrMask,
  input  logic [2:0]           rdAddr,
  output logic [31:0]          rdData,
  input  logic                 txActive,
  input  logic                 rxActive,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  busStrobeT strobe;

  atr_pin_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrMask (wrMask),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  atr_pin_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .txActive (txActive),
    .rxActive (rxActive),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .rdData   (rdData)
  );
endmodule

// File: rtl/atr_pin_bank_chk.sv
module atr_pin_bank_chk #(
  parameter int PIN_COUNT = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [2:0]           wrAddr,
  input logic [2:0]           rdAddr,
  input logic [31:0]          rdData,
  input logic [PIN_COUNT-1:0] pinIn,
  input logic [PIN_COUNT-1:0] pinOe
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: enables are clear on the first cycle out of reset
  a_r1_oe_clear_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0));

  // R3: enables move only after a write to the direction register
  a_r3_oe_needs_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOe) |-> $past(wrEn && (wrAddr == 3'd1)));

  // R2: with no write, a held register read address sees held data
  a_r2_no_write_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && (rdAddr == $past(rdAddr)) && (rdAddr != 3'd7)) |-> $stable(rdData));

  // R7: readback equals pin levels from two cycles earlier
  a_r7_readback_lag: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst >= 2'd2) && (rdAddr == 3'd7)) |-> (rdData[PIN_COUNT-1:0] == $past(pinIn, 2)));
endmodule

bind atr_pin_bank atr_pin_bank_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .pinIn  (pinIn),
  .pinOe  (pinOe)
);

// File: tb/atr_pin_bank_bench.sv
module atr_pin_bank_bench;
  localparam int PINS = 11;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [2:0]      wrAddr = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     wrMask = '0;
  logic [2:0]      rdAddr = '0;
  logic [31:0]     rdData;
  logic            txActive = 1'b0;
  logic            rxActive = 1'b0;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut;
  logic [PINS-1:0] pinOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  atr_pin_bank #(.PIN_COUNT(PINS)) u_atr_pin_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrMask(wrMask), .rdAddr(rdAddr), .rdData(rdData), .txActive(txActive),
    .rxActive(rxActive), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // {tx, rx, expected pinOut} with mode=0x0F0, manual=0x555,
  // idle=0x0F0, rx=0x0A0, tx=0x050, duplex=0x000
  localparam logic [12:0] STATE_VEC [6] = '{
    {2'b00, 11'h5F5}, {2'b01, 11'h5A5}, {2'b10, 11'h555},
    {2'b11, 11'h505}, {2'b01, 11'h5A5}, {2'b00, 11'h5F5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [10:0] prevOut;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 pinOe", 32'(pinOe), 32'h0);
    check("R1 pinOut", 32'(pinOut), 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg zero", v, 32'h0);
    end

    // configure for the state table
    wr(3'd2, 32'h555, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0F0, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0A0, 32'hFFFF_FFFF);
    wr(3'd5, 32'h050, 32'hFFFF_FFFF);
    wr(3'd6, 32'h000, 32'hFFFF_FFFF);
    @(negedge clk);
    // R4: all pins manual
    check("R4 manual value", 32'(pinOut), 32'h555);
    wr(3'd0, 32'h0F0, 32'hFFFF_FFFF);
    @(negedge clk);
    prevOut = pinOut;

    // R5/R6: walk the activity states
    for (int i = 0; i < 6; i++) begin
      {txActive, rxActive} = STATE_VEC[i][12:11];
      #1;
      check("R6 no early change", 32'(pinOut), 32'(prevOut));
      @(negedge clk);
      check("R5 state select", 32'(pinOut), 32'(STATE_VEC[i][10:0]));
      prevOut = pinOut;
    end

    // R2/R3: masked write to direction
    wr(3'd1, 32'h7FF, 32'hFFFF_FFFF);
    wr(3'd1, 32'h000, 32'h00F);
    rd(3'd1, v);
    check("R2 masked write", v, 32'h7F0);
    check("R3 oe follows dir", 32'(pinOe), 32'h7F0);
    wr(3'd0, 32'h7FF, 32'hFFFF_FFFF);
    check("R3 oe ignores mode", 32'(pinOe), 32'h7F0);
    rd(3'd0, v);
    check("R8 mode readback", v, 32'h7FF);

    // R7: two-flop readback lag
    @(negedge clk);
    pinIn = 11'h3C5;
    @(negedge clk);
    rd(3'd7, v);
    check("R7 not after one edge", v, 32'h0);
    @(negedge clk);
    rd(3'd7, v);
    check("R7 after two edges", v, 32'h3C5);

    // R8: write to readback ignored, upper bits read zero
    wr(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(3'd7, v);
    check("R8 readback write ignored", v, 32'h3C5);
    rd(3'd1, v);
    check("R8 dir untouched", v, 32'h7F0);
    rd(3'd2, v);
    check("R8 manual untouched", v, 32'h555);
    wr(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(3'd2, v);
    check("R8 upper bits zero", v, 32'h7FF);

    finish_run();
  end
endmodule